// File: doc/BRIEF.md
# Raster Pixel Fetch Requester

This block feeds a display path from a frame buffer held in shared memory. It owns a read-only, high-priority read port of a memory bus. It keeps a raster scan position and turns each position into a byte address. It issues one single-beat read per pixel. It then splits each returned 32-bit word into alpha, red, green and blue bytes and pushes them into the display FIFO. The FIFO's ready signal gates both request issue and response acceptance. Requests therefore stop whenever the display side has no room, and the priority port is never held continuously.

Two frame buffers sit back to back in memory. A buffer-select input picks the one to read from. The block registers this input once per cycle before it affects an address.

The request side is a two-state machine. In `ST_IDLE` the address comes live from the scan position and the registered select. The transition `idle_to_stall` fires when a request is offered (FIFO ready) but the bus is not ready. It moves to `ST_STALL`, which presents a frozen copy of the offered address. The transition `stall_to_idle` fires when the bus accepts the request or when the FIFO withdraws it. Otherwise the machine stays in `ST_STALL` through the `stall_hold` transition.

Top module: `raster_fetch`

## Requirements
- R1: After synchronous active-high reset the scan position is (0,0), so the first request with buffer select 0 carries address 0.
- R2: The read-request valid output is high exactly when the FIFO ready input is high.
- R3: The scan position moves forward by one pixel only on a cycle where both FIFO ready and bus read-request ready are high; on any other cycle it is unchanged.
- R4: x runs from 0 to FRAME_W-1. When x wraps to 0, y increments. From the last pixel (FRAME_W-1, FRAME_H-1) the position returns to (0,0).
- R5: The request address is (y*FRAME_W + x)*4, plus FRAME_W*FRAME_H*4 when the registered buffer select is 1.
- R6: The buffer-select input is registered. A change on it reaches the address on the cycle after the clock edge that samples it, not in the same cycle.
- R7: Every offered request carries length 0, size code 2 (4 bytes) and burst type FIXED, encoded as 2'b00.
- R8: While a request is offered and not accepted, the address does not change on the following cycle if the request is still offered, even if the buffer select changes.
- R9: The read-data ready output equals the FIFO ready input.
- R10: The FIFO push output equals the read-data valid input. The pixel outputs take byte 0 (bits 7:0) as alpha, byte 1 as red, byte 2 as green and byte 3 (bits 31:24) as blue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_ready | input | 1 | Display FIFO has room |
| buf_sel | input | 1 | Frame buffer to read (0 or 1) |
| ar_valid | output | 1 | Read request offered |
| ar_ready | input | 1 | Bus accepts read request |
| ar_addr | output | ADDR_W | Read byte address |
| ar_len | output | 8 | Beats minus one (always 0) |
| ar_size | output | 3 | Log2 of bytes per beat (always 2) |
| ar_burst | output | 2 | Burst type (always FIXED) |
| r_valid | input | 1 | Read data valid |
| r_data | input | 32 | Read data word |
| r_ready | output | 1 | Read data accepted |
| pix_push | output | 1 | Write pixel into display FIFO |
| pix_a | output | 8 | Alpha byte |
| pix_r | output | 8 | Red byte |
| pix_g | output | 8 | Green byte |
| pix_b | output | 8 | Blue byte |

## Verification
An accepted request, which advances the scan position, and a returning read beat, which pushes a pixel, can land in the same cycle. Both sides also depend on the one FIFO ready input. The random phase toggles FIFO ready, bus request ready and read-data valid independently every cycle, so both handshakes often coincide. A scoreboard compares each accepted address against a queue of raster-ordered expectations. In the same cycle, the push flag, the data ready and the four pixel bytes are compared with the incoming word. A dropped or doubled advance during a coincident pixel push therefore shows up as an address mismatch.

// File: rtl/raster_fetch_pkg.sv
package raster_fetch_pkg;

    typedef enum logic [1:0] {
        BURST_FIXED = 2'b00,
        BURST_INCR  = 2'b01,
        BURST_WRAP  = 2'b10
    } burst_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } req_state_e;

    localparam int BYTES_PER_PIX = 4;
    localparam int LANES         = 4;
    localparam logic [2:0] SIZE_CODE = 3'd2;

endpackage

// File: rtl/scan_position.sv
module scan_position #(
    parameter int FRAME_W = 8,
    parameter int FRAME_H = 4,
    parameter int XW      = 3,
    parameter int YW      = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [XW-1:0] pos_x,
    output logic [YW-1:0] pos_y
);
    localparam logic [XW-1:0] X_LAST = XW'(FRAME_W - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(FRAME_H - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_x <= '0;
            pos_y <= '0;
        end else if (adv) begin
            if (pos_x == X_LAST) begin
                pos_x <= '0;
                pos_y <= (pos_y == Y_LAST) ? '0 : pos_y + 1'b1;
            end else begin
                pos_x <= pos_x + 1'b1;
            end
        end
    end

    // R3: no movement without an accepted request
    p_hold_pos_r3: assert property (@(posedge clk) disable iff (rst)
        !adv |=> ($stable(pos_x) && $stable(pos_y)));

    // R4: end of line returns x to zero
    p_xwrap_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && pos_x == X_LAST) |=> (pos_x == '0));

    // R4: last pixel of the frame returns to the origin
    p_frame_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && pos_x == X_LAST && pos_y == Y_LAST) |=> (pos_y == '0));
endmodule

// File: rtl/addr_former.sv
module addr_former #(
    parameter int FRAME_W = 8,
    parameter int FRAME_H = 4,
    parameter int XW      = 3,
    parameter int YW      = 2,
    parameter int ADDR_W  = 32
) (
    input  logic [XW-1:0]     pos_x,
    input  logic [YW-1:0]     pos_y,
    input  logic              buf_bit,
    output logic [ADDR_W-1:0] addr
);
    import raster_fetch_pkg::*;

    localparam logic [ADDR_W-1:0] BUF_OFF = ADDR_W'(FRAME_W * FRAME_H * BYTES_PER_PIX);
    localparam int SHIFT = $clog2(BYTES_PER_PIX);

    logic [ADDR_W-1:0] linear;

    always_comb begin
        linear = ADDR_W'(pos_y) * ADDR_W'(FRAME_W) + ADDR_W'(pos_x);
        addr   = (linear << SHIFT) + (buf_bit ? BUF_OFF : '0);
    end
endmodule

// File: rtl/pixel_unpack.sv
module pixel_unpack (
    input  logic [31:0] word,
    output logic [7:0]  alpha,
    output logic [7:0]  red,
    output logic [7:0]  green,
    output logic [7:0]  blue
);
    import raster_fetch_pkg::*;

    logic [7:0] lane [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane[i] = word[8*i +: 8];
    end

    assign alpha = lane[0];
    assign red   = lane[1];
    assign green = lane[2];
    assign blue  = lane[3];
endmodule

// File: rtl/raster_fetch.sv
module raster_fetch #(
    parameter int FRAME_W = 8,
    parameter int FRAME_H = 4,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_ready,
    input  logic              buf_sel,
    output logic              ar_valid,
    input  logic              ar_ready,
    output logic [ADDR_W-1:0] ar_addr,
    output logic [7:0]        ar_len,
    output logic [2:0]        ar_size,
    output logic [1:0]        ar_burst,
    input  logic              r_valid,
    input  logic [31:0]       r_data,
    output logic              r_ready,
    output logic              pix_push,
    output logic [7:0]        pix_a,
    output logic [7:0]        pix_r,
    output logic [7:0]        pix_g,
    output logic [7:0]        pix_b
);
    import raster_fetch_pkg::*;

    localparam int XW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1;
    localparam int YW = (FRAME_H > 1) ? $clog2(FRAME_H) : 1;
    localparam logic [ADDR_W-1:0] BUF_OFF = ADDR_W'(FRAME_W * FRAME_H * BYTES_PER_PIX);

    req_state_e        state_q, state_d;
    logic              sel_q;
    logic [ADDR_W-1:0] hold_addr;
    logic [ADDR_W-1:0] live_addr;
    logic [XW-1:0]     pos_x;
    logic [YW-1:0]     pos_y;
    logic              adv;

    assign adv = fifo_ready && ar_ready;

    scan_position #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .XW(XW), .YW(YW)
    ) u_pos (
        .clk(clk), .rst(rst), .adv(adv), .pos_x(pos_x), .pos_y(pos_y)
    );

    addr_former #(
        .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .XW(XW), .YW(YW), .ADDR_W(ADDR_W)
    ) u_addr (
        .pos_x(pos_x), .pos_y(pos_y), .buf_bit(sel_q), .addr(live_addr)
    );

    pixel_unpack u_unpack (
        .word(r_data), .alpha(pix_a), .red(pix_r), .green(pix_g), .blue(pix_b)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fifo_ready && !ar_ready) state_d = ST_STALL;
            ST_STALL: if (!fifo_ready || ar_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // select register and frozen address
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= 1'b0;
            hold_addr <= '0;
        end else begin
            sel_q <= buf_sel;
            if (state_q == ST_IDLE && state_d == ST_STALL) hold_addr <= live_addr;
        end
    end

    // outputs
    always_comb begin
        ar_valid = fifo_ready;
        ar_len   = 8'd0;
        ar_size  = SIZE_CODE;
        ar_burst = BURST_FIXED;
        r_ready  = fifo_ready;
        pix_push = r_valid;
        unique case (state_q)
            ST_IDLE:  ar_addr = live_addr;
            ST_STALL: ar_addr = hold_addr;
            default:  ar_addr = live_addr;
        endcase
    end

    // R8: pending request keeps its address
    p_hold_addr_r8: assert property (@(posedge clk) disable iff (rst)
        (ar_valid && !ar_ready) |=> (!ar_valid || $stable(ar_addr)));

    // R6: outside a stall the buffer region follows last cycle's select
    p_buf_region_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !$past(rst)) |-> ((ar_addr >= BUF_OFF) == $past(buf_sel)));
endmodule

// File: tb/raster_fetch_bench.sv
module raster_fetch_bench;
    localparam int W  = 8;
    localparam int H  = 4;
    localparam int AW = 32;
    localparam logic [31:0] OFF = 32'(W * H * 4);

    logic          clk = 1'b0;
    logic          rst;
    logic          fifo_ready, buf_sel, ar_ready, r_valid;
    logic [31:0]   r_data;
    logic          ar_valid, r_ready, pix_push;
    logic [AW-1:0] ar_addr;
    logic [7:0]    ar_len, pix_a, pix_r, pix_g, pix_b;
    logic [2:0]    ar_size;
    logic [1:0]    ar_burst;

    raster_fetch #(.FRAME_W(W), .FRAME_H(H), .ADDR_W(AW)) u_raster_fetch (
        .clk(clk), .rst(rst), .fifo_ready(fifo_ready), .buf_sel(buf_sel),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
        .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst),
        .r_valid(r_valid), .r_data(r_data), .r_ready(r_ready),
        .pix_push(pix_push), .pix_a(pix_a), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b)
    );

    always #2 clk = ~clk;

    int          total = 0;
    int          bad   = 0;
    bit          done  = 0;
    logic [31:0] expq[$];
    int          bx = 0, by = 0;
    string       phase = "R5";

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_addr(input int x, input int y, input int s);
        return 32'((y * W + x) * 4 + s * W * H * 4);
    endfunction

    // driver side: expected accepted addresses in raster order
    task automatic push_expect(input int n, input int s);
        for (int i = 0; i < n; i++) begin
            expq.push_back(model_addr(bx, by, s));
            if (bx == W - 1) begin
                bx = 0;
                by = (by == H - 1) ? 0 : by + 1;
            end else bx++;
        end
    endtask

    // monitor side
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(ar_valid == fifo_ready, "R2", 32'(ar_valid), 32'(fifo_ready));
            check(r_ready == fifo_ready, "R9", 32'(r_ready), 32'(fifo_ready));
            check(pix_push == r_valid, "R10", 32'(pix_push), 32'(r_valid));
            if (r_valid)
                check({pix_b, pix_g, pix_r, pix_a} == r_data, "R10", {pix_b, pix_g, pix_r, pix_a}, r_data);
            if (ar_valid)
                check({ar_len, ar_size, ar_burst} == {8'd0, 3'd2, 2'b00}, "R7",
                      32'({ar_len, ar_size, ar_burst}), 32'({8'd0, 3'd2, 2'b00}));
            if (ar_valid && ar_ready) begin
                if (expq.size() == 0) check(1'b0, "R3", ar_addr, 32'hFFFF_FFFF);
                else begin
                    logic [31:0] e;
                    e = expq.pop_front();
                    check(ar_addr == e, phase, ar_addr, e);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // run until the scoreboard queue drains; rnd picks random handshakes
    task automatic drain(input bit rnd);
        logic [15:0] lf = 16'hACE1;
        for (int c = 0; c < 5000; c++) begin
            tick();
            if (expq.size() == 0) begin
                ar_ready = 1'b0;
                fifo_ready = 1'b0;
                r_valid = 1'b0;
                return;
            end
            if (rnd) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                ar_ready   = lf[0];
                fifo_ready = lf[3] | lf[7];
                r_valid    = lf[5];
                r_data     = {lf, lf ^ 16'h5A3C};
            end else begin
                ar_ready   = 1'b1;
                fifo_ready = 1'b1;
            end
        end
        check(1'b0, "R3", 32'(expq.size()), 32'd0);
    endtask

    initial begin
        logic [31:0] held;
        rst = 1'b1; fifo_ready = 1'b1; buf_sel = 1'b0; ar_ready = 1'b0;
        r_valid = 1'b0; r_data = '0;
        repeat (3) tick();
        rst = 1'b0;
        @(negedge clk);
        check(ar_addr == 32'd0, "R1", ar_addr, 32'd0);
        check(ar_valid == 1'b1, "R1", 32'(ar_valid), 32'd1);

        // R4: full frame plus a few, wrapping back to origin
        tick(); fifo_ready = 1'b0; tick();
        phase = "R4";
        push_expect(W * H + 5, 0);
        drain(1'b0);

        // R3: random throttling with coincident pixel pushes
        phase = "R3";
        push_expect(40, 0);
        drain(1'b1);

        // R8: stall with select change
        tick(); fifo_ready = 1'b1; ar_ready = 1'b0;
        tick();
        @(negedge clk);
        held = ar_addr;
        check(held == model_addr(bx, by, 0), "R8", held, model_addr(bx, by, 0));
        tick(); buf_sel = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ar_addr == held, "R8", ar_addr, held);
        end
        tick(); fifo_ready = 1'b0;
        tick(); fifo_ready = 1'b1;
        @(negedge clk);
        check(ar_addr == held + OFF, "R6", ar_addr, held + OFF);

        // R6: one-cycle delay on select
        tick(); fifo_ready = 1'b0;
        tick(); buf_sel = 1'b0;
        @(negedge clk);
        check(ar_addr == model_addr(bx, by, 1), "R6", ar_addr, model_addr(bx, by, 1));
        @(negedge clk);
        check(ar_addr == model_addr(bx, by, 0), "R6", ar_addr, model_addr(bx, by, 0));

        // stream from buffer 1
        tick(); buf_sel = 1'b1;
        tick();
        phase = "R5";
        push_expect(12, 1);
        drain(1'b1);

        // R10 / R9: fixed word, then with FIFO full
        tick(); fifo_ready = 1'b1; r_valid = 1'b1; r_data = 32'h4433_2211;
        @(negedge clk);
        check({pix_a, pix_r, pix_g, pix_b} == 32'h1122_3344, "R10",
              {pix_a, pix_r, pix_g, pix_b}, 32'h1122_3344);
        tick(); fifo_ready = 1'b0;
        @(negedge clk);
        check(pix_push == 1'b1 && r_ready == 1'b0, "R9", 32'({pix_push, r_ready}), 32'b10);
        tick(); r_valid = 1'b0;
        @(negedge clk);
        check(pix_push == 1'b0, "R10", 32'(pix_push), 32'd0);
        check(expq.size() == 0, "R3", 32'(expq.size()), 32'd0);

        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=0", expq.size());
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule